// File: doc/BRIEF.md
# Configuration Image Byte Streamer

This block loads a programmable device through its byte-wide configuration port. After a start pulse it raises a one-cycle reset strobe toward the device and waits a settle interval. It then writes one zero byte to the port. Next it pulls a 16-byte header from a ready/valid byte source and reads the payload length from that header. It forwards exactly that many payload bytes to the port in order and follows them with a fixed run of zero filler bytes.

When the last filler byte has been accepted, the block samples the device's error line. If the line is high, the block reports failure and keeps the interrupt enable low. If the line is low, it waits a second settle interval, then reports success and raises the interrupt enable. Before any of this, the caller states the image size. An image too short to hold a header is refused at once.

Top module: `cfg_image_streamer`

## Requirements
- R1: A start pulse given with an image size below 16 bytes sets the failure flag on the next cycle. No reset strobe is issued, no port byte is written and no source byte is read.
- R2: An accepted start produces exactly one reset strobe, one cycle wide. At least SETTLE_CYC cycles then pass before the first port write.
- R3: The first byte written to the port after the settle wait is 0x00. It is written before any header byte is read.
- R4: Exactly 16 header bytes are read from the source. The payload length is the 32-bit value formed from header bytes 0..3, with byte 0 most significant. Header bytes 4..15 have no effect on the output.
- R5: The payload is forwarded unchanged, in source order, one port write per byte. Exactly as many bytes are forwarded as the length field gives. A length of zero forwards none.
- R6: Exactly five 0x00 filler bytes follow the payload on the port.
- R7: While a port byte is offered and not accepted, the valid signal and the data stay unchanged. The source is stalled during this time.
- R8: If the error input is high when sampled after the last filler, the failure flag is set, the done flag stays low and the interrupt enable stays low.
- R9: If the error input is low when sampled, the block waits a further settle interval, then sets done and the interrupt enable together.
- R10: busy is high from an accepted start until done or failure is reported. The result flags hold until the next start, and a start pulse while busy is ignored.
- R11: Out of reset the block is idle, with no strobe, no port byte, no source read and all status outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start request |
| img_size_i | input | 32 | Total image size in bytes, sampled at start |
| src_data_i | input | 8 | Image byte from the source |
| src_valid_i | input | 1 | Source byte valid |
| src_ready_o | output | 1 | Block accepts the source byte |
| cfg_rst_o | output | 1 | Reset strobe to the programmable device |
| cfg_data_o | output | 8 | Byte for the configuration port |
| cfg_valid_o | output | 1 | Port byte valid |
| cfg_ready_i | input | 1 | Port accepts the byte |
| cfg_err_i | input | 1 | Device error line, sampled after the fillers |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load succeeded (held) |
| fail_o | output | 1 | Load refused or failed (held) |
| irq_en_o | output | 1 | Interrupt enable, raised only on success |

## Verification
The bench uses a 258-byte payload, so header byte 2 carries a nonzero weight. A design that read the length little-endian would stream about 33 million bytes and hang. It also runs an empty payload, where a design that decrements before testing would wrap the length counter. Both the port and the source stall in irregular patterns. A design that changed its port data while stalled, or took a source byte it could not pass on, would corrupt the scoreboard order. The remaining runs cover three things. Two runs share a payload but differ in header bytes 4..15, which must give identical output. A start pulse arrives mid-load, which must neither restart the load nor add a strobe. The error line is driven high, which must leave the done flag and the interrupt enable low.

// File: rtl/cfgstr_pkg.sv
package cfgstr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STROBE,
        ST_WAIT0,
        ST_DUMMY,
        ST_HEAD,
        ST_BODY,
        ST_FILL,
        ST_CHECK,
        ST_WAIT1
    } strm_state_e;

    localparam logic [7:0] PAD_BYTE = 8'h00;

endpackage

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic expired
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (arm) begin
            cnt_d = CW'(CYCLES - 1);
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == '0);

    assert_arm_run_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm && run));

endmodule

// File: rtl/cfg_header_parser.sv
module cfg_header_parser #(
    parameter int HDR_N     = 16,
    parameter int LEN_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   take,
    input  logic [7:0]             byte_i,
    output logic                   full,
    output logic [8*LEN_BYTES-1:0] length
);
    localparam int LEN_W = 8 * LEN_BYTES;
    localparam int IW    = $clog2(HDR_N + 1);

    logic [IW-1:0]    idx_d, idx_q;
    logic [LEN_W-1:0] len_d, len_q;

    always_comb begin
        idx_d = idx_q;
        len_d = len_q;
        if (clear) begin
            idx_d = '0;
            len_d = '0;
        end else if (take && idx_q != IW'(HDR_N)) begin
            idx_d = idx_q + 1'b1;
            if (idx_q < IW'(LEN_BYTES)) begin
                len_d = {len_q[LEN_W-9:0], byte_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            len_q <= '0;
        end else begin
            idx_q <= idx_d;
            len_q <= len_d;
        end
    end

    assign full   = (idx_q == IW'(HDR_N));
    assign length = len_q;

    assert_hdr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IW'(HDR_N));
    assert_no_take_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full && !clear |=> full && $stable(length));

endmodule

// File: rtl/cfg_image_streamer.sv
module cfg_image_streamer
    import cfgstr_pkg::*;
#(
    parameter int SETTLE_CYC = 64,
    parameter int FILL_N     = 5,
    parameter int HDR_N      = 16,
    parameter int LEN_BYTES  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] img_size_i,
    input  logic [7:0]  src_data_i,
    input  logic        src_valid_i,
    output logic        src_ready_o,
    output logic        cfg_rst_o,
    output logic [7:0]  cfg_data_o,
    output logic        cfg_valid_o,
    input  logic        cfg_ready_i,
    input  logic        cfg_err_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        fail_o,
    output logic        irq_en_o
);
    localparam int LEN_W  = 8 * LEN_BYTES;
    localparam int FILL_W = $clog2(FILL_N + 1);

    typedef struct packed {
        strm_state_e       st;
        logic [7:0]        obyte;
        logic              ovld;
        logic [LEN_W-1:0]  left;
        logic [FILL_W-1:0] fill;
        logic              done;
        logic              fail;
        logic              irq;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             out_free;
    logic             tmr_arm, tmr_run, tmr_exp;
    logic             hdr_clear, hdr_take, hdr_full;
    logic [LEN_W-1:0] hdr_len;

    cfg_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (tmr_arm),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    cfg_header_parser #(.HDR_N(HDR_N), .LEN_BYTES(LEN_BYTES)) u_header (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (hdr_clear),
        .take   (hdr_take),
        .byte_i (src_data_i),
        .full   (hdr_full),
        .length (hdr_len)
    );

    always_comb begin
        c_d         = c_q;
        src_ready_o = 1'b0;
        hdr_take    = 1'b0;
        hdr_clear   = 1'b0;
        tmr_arm     = 1'b0;
        tmr_run     = (c_q.st == ST_WAIT0) || (c_q.st == ST_WAIT1);
        out_free    = !c_q.ovld || cfg_ready_i;

        if (c_q.ovld && cfg_ready_i) begin
            c_d.ovld = 1'b0;
        end

        case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.done = 1'b0;
                    c_d.fail = 1'b0;
                    c_d.irq  = 1'b0;
                    if (img_size_i < 32'(HDR_N)) begin
                        c_d.fail = 1'b1;
                    end else begin
                        c_d.st = ST_STROBE;
                    end
                end
            end
            ST_STROBE: begin
                tmr_arm   = 1'b1;
                hdr_clear = 1'b1;
                c_d.st    = ST_WAIT0;
            end
            ST_WAIT0: begin
                if (tmr_exp) c_d.st = ST_DUMMY;
            end
            ST_DUMMY: begin
                if (out_free) begin
                    c_d.obyte = PAD_BYTE;
                    c_d.ovld  = 1'b1;
                    c_d.st    = ST_HEAD;
                end
            end
            ST_HEAD: begin
                if (hdr_full) begin
                    c_d.left = hdr_len;
                    c_d.st   = ST_BODY;
                end else begin
                    src_ready_o = 1'b1;
                    hdr_take    = src_valid_i;
                end
            end
            ST_BODY: begin
                if (c_q.left == '0) begin
                    c_d.fill = '0;
                    c_d.st   = ST_FILL;
                end else begin
                    src_ready_o = out_free;
                    if (src_valid_i && out_free) begin
                        c_d.obyte = src_data_i;
                        c_d.ovld  = 1'b1;
                        c_d.left  = c_q.left - 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (c_q.fill == FILL_W'(FILL_N)) begin
                    if (out_free) c_d.st = ST_CHECK;
                end else if (out_free) begin
                    c_d.obyte = PAD_BYTE;
                    c_d.ovld  = 1'b1;
                    c_d.fill  = c_q.fill + 1'b1;
                end
            end
            ST_CHECK: begin
                if (cfg_err_i) begin
                    c_d.fail = 1'b1;
                    c_d.st   = ST_IDLE;
                end else begin
                    tmr_arm = 1'b1;
                    c_d.st  = ST_WAIT1;
                end
            end
            ST_WAIT1: begin
                if (tmr_exp) begin
                    c_d.done = 1'b1;
                    c_d.irq  = 1'b1;
                    c_d.st   = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, obyte: '0, ovld: 1'b0, left: '0,
                     fill: '0, done: 1'b0, fail: 1'b0, irq: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign cfg_rst_o   = (c_q.st == ST_STROBE);
    assign cfg_data_o  = c_q.obyte;
    assign cfg_valid_o = c_q.ovld;
    assign busy_o      = (c_q.st != ST_IDLE);
    assign done_o      = c_q.done;
    assign fail_o      = c_q.fail;
    assign irq_en_o    = c_q.irq;

    assert_port_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o && !cfg_ready_i |=> cfg_valid_o && $stable(cfg_data_o));
    assert_src_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready_o |-> busy_o);
    assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    assert_irq_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en_o |-> done_o);
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_o |=> !cfg_rst_o && !cfg_valid_o);
    assert_short_refused_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (img_size_i < 32'(HDR_N)) |=> fail_o && !busy_o);

endmodule

// File: tb/test_cfg_image_streamer.sv
module test_cfg_image_streamer;
    localparam int SETTLE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] img_size_i = '0;
    logic [7:0]  src_data_i = '0;
    logic        src_valid_i = 1'b0;
    logic        src_ready_o;
    logic        cfg_rst_o;
    logic [7:0]  cfg_data_o;
    logic        cfg_valid_o;
    logic        cfg_ready_i = 1'b1;
    logic        cfg_err_i = 1'b0;
    logic        busy_o, done_o, fail_o, irq_en_o;

    always #5 clk = ~clk;

    cfg_image_streamer #(.SETTLE_CYC(SETTLE)) i_cfg_image_streamer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .img_size_i(img_size_i),
        .src_data_i(src_data_i), .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
        .cfg_rst_o(cfg_rst_o), .cfg_data_o(cfg_data_o), .cfg_valid_o(cfg_valid_o),
        .cfg_ready_i(cfg_ready_i), .cfg_err_i(cfg_err_i), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .irq_en_o(irq_en_o)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    logic [7:0] img [0:511];
    int  src_len = 0, src_idx = 0, src_taken = 0;
    bit  src_en = 0, bp = 0, gaps = 0;
    longint cyc = 0;
    int  strobes = 0;
    longint strobe_cyc = 0, first_wr_cyc = 0;
    bit  seen_wr = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: scoreboard pop on each port handshake
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_rst_o) begin
                strobes++;
                strobe_cyc = cyc;
            end
            if (cfg_valid_o && cfg_ready_i) begin
                if (!seen_wr) first_wr_cyc = cyc;
                seen_wr = 1;
                if (exp_q.size() == 0) begin
                    chk(0, "R1/R5", "unexpected port write", cfg_data_o, -1);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    chk(cfg_data_o == e, "R3/R5/R6", "port byte", cfg_data_o, e);
                end
            end
        end
    end

    // source and port-ready driver
    always begin
        bit take;
        @(negedge clk);
        take = src_valid_i && src_ready_o;
        @(posedge clk);
        #1;
        if (take) begin
            src_idx++;
            src_taken++;
        end
        src_valid_i = src_en && (src_idx < src_len) && (!gaps || (cyc % 4 != 0));
        src_data_i  = img[src_idx % 512];
        cfg_ready_i = !bp || (cyc % 3 != 1);
    end

    task automatic pulse_start();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    task automatic run_image(int len, bit err, bit b, bit g, bit restart, logic [7:0] hfill);
        int n;
        img[0] = 8'(len >> 24); img[1] = 8'(len >> 16);
        img[2] = 8'(len >> 8);  img[3] = 8'(len);
        for (int i = 4; i < 16; i++) img[i] = hfill ^ 8'(i);
        exp_q.delete();
        exp_q.push_back(8'h00);
        for (int i = 0; i < len; i++) begin
            img[16 + i] = 8'(i * 7 + 3);
            exp_q.push_back(8'(i * 7 + 3));
        end
        for (int i = 0; i < 5; i++) exp_q.push_back(8'h00);
        src_idx = 0; src_taken = 0; src_len = 16 + len; src_en = 1;
        strobes = 0; seen_wr = 0; bp = b; gaps = g; cfg_err_i = err;
        img_size_i = 32'(16 + len);
        pulse_start();
        n = 0;
        @(negedge clk);
        while (busy_o && n < 20000) begin
            if (restart && n == 40) pulse_start();
            @(negedge clk);
            n++;
        end
        chk(n < 20000, "R10", "load finished", n, 0);
        chk(exp_q.size() == 0, "R5/R6", "bytes left unwritten", exp_q.size(), 0);
        chk(src_taken == 16 + len, "R4", "source bytes read", src_taken, 16 + len);
        chk(strobes == 1, "R2", "reset strobes", strobes, 1);
        chk(first_wr_cyc - strobe_cyc >= SETTLE, "R2", "settle gap", first_wr_cyc - strobe_cyc, SETTLE);
        chk(fail_o == err, "R8", "fail flag", fail_o, err);
        chk(done_o == !err, "R9", "done flag", done_o, !err);
        chk(irq_en_o == !err, "R8/R9", "interrupt enable", irq_en_o, !err);
        repeat (5) @(negedge clk);
        chk(done_o == !err && fail_o == err && !busy_o, "R10", "result held", done_o, !err);
        chk(src_ready_o == 0 && src_taken == 16 + len, "R10", "source quiet", src_taken, 16 + len);
        src_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy_o && !done_o && !fail_o && !irq_en_o, "R11", "status after reset", busy_o, 0);
        chk(!cfg_valid_o && !cfg_rst_o && !src_ready_o, "R11", "outputs after reset", cfg_valid_o, 0);

        run_image(3, 0, 0, 0, 0, 8'h5A);
        run_image(3, 0, 0, 0, 0, 8'hC3);     // R4 header bytes 4..15 differ
        run_image(20, 0, 1, 1, 1, 8'h11);    // R7 stalls, R10 start while busy
        run_image(0, 0, 0, 0, 0, 8'h00);     // R5 empty payload
        run_image(258, 0, 1, 0, 0, 8'hFF);   // R4 big-endian length
        run_image(5, 1, 0, 1, 0, 8'h22);     // R8 error line set

        // R1 short image refused
        exp_q.delete();
        src_idx = 0; src_taken = 0; src_len = 16; src_en = 1;
        strobes = 0; seen_wr = 0; cfg_err_i = 0; bp = 0; gaps = 0;
        img_size_i = 32'd10;
        pulse_start();
        repeat (SETTLE + 30) @(negedge clk);
        chk(fail_o && !done_o && !busy_o, "R1", "short image flag", fail_o, 1);
        chk(strobes == 0 && !seen_wr, "R1", "no strobe or port write", strobes, 0);
        chk(src_taken == 0, "R1", "no source read", src_taken, 0);
        src_en = 0;

        run_image(4, 0, 1, 1, 0, 8'h77);     // R9 recovery after failure

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule